// File: doc/BRIEF.md
# Checkpoint First-Write Undo Logger

This block sits in front of the write path of a cache-backed memory and collects what is needed to roll that memory back to the latest checkpoint. Each cache line has a one-bit "touched" flag. The first write that reaches a line after a checkpoint finds the flag clear. That write is held back while the block reads the line's current contents and emits them as an undo record. The record carries the checkpoint epoch, the line index and the old data. Once the record is accepted, the flag is set and the write goes through. Later writes to the same line in the same epoch pass straight through and produce no record.

A single-cycle checkpoint pulse clears every flag at once. It also moves the epoch counter forward through a ring of retained log regions, four by default, so the epoch wraps modulo that count. The system is expected to be quiet at a checkpoint. If a pulse arrives while an undo record is still in flight, it is held and applied as soon as that record has drained.

The write request port and the undo-log output are valid/ready streams. A request must hold its line and data stable while `wr_valid` is high and `wr_ready` is low. A record is held stable while `log_valid` is high and `log_ready` is low. The line read port has a one-cycle latency: the data for a read issued with `rd_en` is expected on `rd_data` in the next cycle. The checkpoint pulse and the epoch output are plain signals with no handshake.

Top module: `ckpt_undo_logger`

## Requirements
- R1: After reset the epoch is 0, every touched flag is clear, `log_valid` is 0 and `rd_en` is 0.
- R2: A write request to a line whose flag is clear raises `rd_en` with `rd_line` equal to the requested line in the cycle the request is first seen. Two cycles later `log_valid` rises. The record carries the current epoch, the line, and the `rd_data` returned one cycle after the read.
- R3: A write that needs an undo record keeps `wr_ready` low until the record has been accepted. With `log_ready` held high, the write is accepted three cycles after the request is first seen.
- R4: A write request to a line whose flag is already set is accepted in the cycle it is first seen, with no read and no undo record.
- R5: While `log_valid` is high and `log_ready` is low, `log_valid` stays high and `log_epoch`, `log_line` and `log_data` do not change.
- R6: A checkpoint pulse seen while no record is pending clears every flag, and the epoch increments at the next clock edge. In the pulse cycle `wr_ready` and `mem_wr_en` are 0.
- R7: The epoch counts modulo the number of retained regions (default 4), so an increment from 3 gives 0.
- R8: A checkpoint pulse that arrives while an undo record is being fetched or is waiting to be accepted leaves the epoch unchanged until the record is accepted. It then takes effect in the first idle cycle, and the epoch has incremented one cycle after that.
- R9: `mem_wr_en` is high exactly on a write handshake, and carries the request's line and data to the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ckpt_req | input | 1 | Checkpoint pulse |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted |
| wr_line | input | IDX_W | Line index of the write |
| wr_data | input | DATA_W | Line data of the write |
| rd_en | output | 1 | Read of old line contents |
| rd_line | output | IDX_W | Line index to read |
| rd_data | input | DATA_W | Old line contents, one cycle after `rd_en` |
| mem_wr_en | output | 1 | Write strobe to the memory |
| mem_wr_line | output | IDX_W | Line index written |
| mem_wr_data | output | DATA_W | Data written |
| log_valid | output | 1 | Undo record valid |
| log_ready | input | 1 | Undo record accepted by the log sink |
| log_epoch | output | EP_W | Epoch of the record |
| log_line | output | IDX_W | Line index of the record |
| log_data | output | DATA_W | Pre-write contents of the line |
| epoch | output | EP_W | Current checkpoint epoch |

## Verification
For a first write, the read strobe is due in the request cycle, the record two cycles later, and the write handshake one cycle after the record is accepted. A write to a touched line completes in its own cycle. The bench drives inputs on the falling edge and samples one time unit later, counting cycles from the request, so each check lands in the cycle its result is due. After a checkpoint pulse, the epoch is read just after the following rising edge. A deferred pulse is followed cycle by cycle: the epoch must stay put through the stall and the drain cycle, and must have moved one cycle later.

// File: rtl/ckpt_undo_pkg.sv
package ckpt_undo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LOG   = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/line_flag_bank.sv
module line_flag_bank #(
  parameter int IDX_W = 4,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] query_idx,
  output logic             query_hit
);
  logic [LINES-1:0] touched;

  for (genvar i = 0; i < LINES; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n || clear_all) touched[i] <= 1'b0;
      else if (set_en && set_idx == IDX_W'(i)) touched[i] <= 1'b1;
    end
  end

  assign query_hit = touched[query_idx];

  // a set and a bulk clear never meet: checkpoints apply only when idle
  p_set_clear_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clear_all));

  // bulk clear empties every flag
  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (touched == '0));
endmodule

// File: rtl/epoch_ring.sv
module epoch_ring #(
  parameter int EPOCHS = 4,
  localparam int EP_W = (EPOCHS > 1) ? $clog2(EPOCHS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  output logic [EP_W-1:0] epoch
);
  localparam logic [EP_W-1:0] LAST = EP_W'(EPOCHS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) epoch <= '0;
    else if (advance) epoch <= (epoch == LAST) ? '0 : epoch + 1'b1;
  end

  // epoch never leaves the ring
  p_epoch_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    epoch <= LAST);

  // epoch only moves on an advance
  p_epoch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(epoch));
endmodule

// File: rtl/undo_ctrl.sv
module undo_ctrl
  import ckpt_undo_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  parameter int EP_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ckpt_req,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  wr_line,
  input  logic              line_flagged,
  input  logic [EP_W-1:0]   epoch,
  output logic              wr_ready,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_line,
  input  logic [DATA_W-1:0] rd_data,
  output logic              set_en,
  output logic [IDX_W-1:0]  set_idx,
  output logic              ckpt_apply,
  output logic              log_valid,
  input  logic              log_ready,
  output logic [EP_W-1:0]   log_epoch,
  output logic [IDX_W-1:0]  log_line,
  output logic [DATA_W-1:0] log_data
);
  ctl_state_e        state, state_nx;
  logic              ckpt_held;
  logic              idle, want_ckpt, start_fetch;
  logic [IDX_W-1:0]  pend_line;
  logic [DATA_W-1:0] old_data;
  logic [EP_W-1:0]   old_epoch;

  assign idle        = (state == ST_IDLE);
  assign want_ckpt   = ckpt_req || ckpt_held;
  assign ckpt_apply  = idle && want_ckpt;
  assign start_fetch = idle && !want_ckpt && wr_valid && !line_flagged;
  assign wr_ready    = idle && !want_ckpt && line_flagged;
  assign rd_en       = start_fetch;
  assign rd_line     = wr_line;
  assign log_valid   = (state == ST_LOG);
  assign set_en      = log_valid && log_ready;
  assign set_idx     = pend_line;
  assign log_line    = pend_line;
  assign log_data    = old_data;
  assign log_epoch   = old_epoch;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start_fetch) state_nx = ST_FETCH;
      ST_FETCH: state_nx = ST_LOG;
      ST_LOG:   if (log_ready) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ckpt_held <= 1'b0;
      pend_line <= '0;
      old_data  <= '0;
      old_epoch <= '0;
    end else begin
      state <= state_nx;
      if (ckpt_apply) ckpt_held <= 1'b0;
      else if (ckpt_req) ckpt_held <= 1'b1;
      if (start_fetch) pend_line <= wr_line;
      if (state == ST_FETCH) begin
        old_data  <= rd_data;
        old_epoch <= epoch;
      end
    end
  end

  // record held steady under back-pressure
  p_log_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !log_ready) |=> (log_valid && $stable(log_data)
                                   && $stable(log_line) && $stable(log_epoch)));

  // a record follows its read two cycles later, for the same line
  p_log_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(log_valid) |-> ($past(rd_en, 2) && log_line == $past(rd_line, 2)));

  // a pending record blocks the write it belongs to
  p_wr_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> !wr_ready);

  // a fetch and an accepted write never share a cycle
  p_rd_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !wr_ready);
endmodule

// File: rtl/ckpt_undo_logger.sv
module ckpt_undo_logger #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  parameter int EPOCHS = 4,
  localparam int EP_W = (EPOCHS > 1) ? $clog2(EPOCHS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ckpt_req,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IDX_W-1:0]  wr_line,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_line,
  input  logic [DATA_W-1:0] rd_data,
  output logic              mem_wr_en,
  output logic [IDX_W-1:0]  mem_wr_line,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              log_valid,
  input  logic              log_ready,
  output logic [EP_W-1:0]   log_epoch,
  output logic [IDX_W-1:0]  log_line,
  output logic [DATA_W-1:0] log_data,
  output logic [EP_W-1:0]   epoch
);
  logic             hit, set_en, ckpt_apply;
  logic [IDX_W-1:0] set_idx;

  line_flag_bank #(.IDX_W(IDX_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (ckpt_apply),
    .set_en    (set_en),
    .set_idx   (set_idx),
    .query_idx (wr_line),
    .query_hit (hit)
  );

  epoch_ring #(.EPOCHS(EPOCHS)) u_epoch (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (ckpt_apply),
    .epoch   (epoch)
  );

  undo_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W), .EP_W(EP_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ckpt_req     (ckpt_req),
    .wr_valid     (wr_valid),
    .wr_line      (wr_line),
    .line_flagged (hit),
    .epoch        (epoch),
    .wr_ready     (wr_ready),
    .rd_en        (rd_en),
    .rd_line      (rd_line),
    .rd_data      (rd_data),
    .set_en       (set_en),
    .set_idx      (set_idx),
    .ckpt_apply   (ckpt_apply),
    .log_valid    (log_valid),
    .log_ready    (log_ready),
    .log_epoch    (log_epoch),
    .log_line     (log_line),
    .log_data     (log_data)
  );

  assign mem_wr_en   = wr_valid && wr_ready;
  assign mem_wr_line = wr_line;
  assign mem_wr_data = wr_data;

  // a checkpoint pulse never lets a write through in its cycle
  p_ckpt_blocks_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_req |-> !mem_wr_en);

  // epoch cannot move while a record waits
  p_epoch_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |=> $stable(epoch));

  // memory write only on a handshake, never alongside a record
  p_mem_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (!log_valid && !rd_en));
endmodule

// File: tb/tb_ckpt_undo_logger.sv
module tb_ckpt_undo_logger;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;
  localparam int DATA_W = 32;
  localparam int LINES = 1 << IDX_W;

  typedef struct packed {
    logic [IDX_W-1:0]  line;
    logic [DATA_W-1:0] data;
    logic              logs;
    logic [DATA_W-1:0] old;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd3,  32'h1111_0003, 1'b1, 32'hC0DE_0003},
    '{4'd3,  32'h2222_0003, 1'b0, 32'h0},
    '{4'd7,  32'h1111_0007, 1'b1, 32'hC0DE_0007},
    '{4'd0,  32'h1111_0000, 1'b1, 32'hC0DE_0000},
    '{4'd7,  32'h3333_0007, 1'b0, 32'h0},
    '{4'd15, 32'h1111_000F, 1'b1, 32'hC0DE_000F},
    '{4'd0,  32'h4444_0000, 1'b0, 32'h0},
    '{4'd3,  32'h5555_0003, 1'b0, 32'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ckpt_req = 1'b0, wr_valid = 1'b0, log_ready = 1'b1;
  logic [IDX_W-1:0] wr_line = '0;
  logic [DATA_W-1:0] wr_data = '0, rd_data;
  logic wr_ready, rd_en, mem_wr_en, log_valid;
  logic [IDX_W-1:0] rd_line, mem_wr_line, log_line;
  logic [DATA_W-1:0] mem_wr_data, log_data;
  logic [1:0] log_epoch, epoch;
  logic [DATA_W-1:0] mem [LINES];

  int checks = 0, fails = 0;
  bit finished = 0;

  ckpt_undo_logger dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) mem[i] <= 32'hC0DE_0000 | DATA_W'(i);
      rd_data <= '0;
    end else begin
      if (rd_en) rd_data <= mem[rd_line];
      if (mem_wr_en) mem[mem_wr_line] <= mem_wr_data;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive a write at the falling edge; result: handshake cycle, log count, log fields
  task automatic do_write(input logic [IDX_W-1:0] ln, input logic [DATA_W-1:0] d,
                          input bit exp_log, input logic [DATA_W-1:0] exp_old,
                          input logic [1:0] exp_ep);
    int acc_c = -1, first_log = -1, nlog = 0;
    logic [DATA_W-1:0] g_old = '0;
    logic [1:0] g_ep = '0;
    logic [IDX_W-1:0] g_ln = '0;
    @(negedge clk);
    wr_valid = 1'b1; wr_line = ln; wr_data = d;
    for (int c = 0; c < 40 && acc_c < 0; c++) begin
      #1;
      if (c == 0) check(rd_en == exp_log, exp_log ? "R2 read strobe" : "R4 no read",
                        32'(rd_en), 32'(exp_log));
      if (log_valid && log_ready) begin
        nlog++; g_old = log_data; g_ep = log_epoch; g_ln = log_line;
        if (first_log < 0) first_log = c;
      end
      if (wr_ready) acc_c = c;
      @(negedge clk);
    end
    wr_valid = 1'b0;
    check(nlog == int'(exp_log), "R2/R4 record count", 32'(nlog), 32'(exp_log));
    if (exp_log) begin
      check(first_log == 2, "R2 record timing", 32'(first_log), 32'd2);
      check(g_old == exp_old, "R2 old data", g_old, exp_old);
      check(g_ep == exp_ep, "R2 record epoch", 32'(g_ep), 32'(exp_ep));
      check(g_ln == ln, "R2 record line", 32'(g_ln), 32'(ln));
      check(acc_c == 3, "R3 write accept cycle", 32'(acc_c), 32'd3);
    end else begin
      check(acc_c == 0, "R4 write accept cycle", 32'(acc_c), 32'd0);
    end
    check(mem[ln] == d, "R9 memory written", mem[ln], d);
  endtask

  task automatic pulse_ckpt();
    @(negedge clk); ckpt_req = 1'b1;
    @(negedge clk); ckpt_req = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(epoch == 0, "R1 epoch", 32'(epoch), 0);
    check(!log_valid, "R1 log_valid", 32'(log_valid), 0);
    check(!rd_en, "R1 rd_en", 32'(rd_en), 0);
    wr_valid = 1'b1; wr_line = 4'd12; #1;
    check(rd_en, "R1 flags clear", 32'(rd_en), 1);
    wr_valid = 1'b0; #1;

    foreach (VECS[i])
      do_write(VECS[i].line, VECS[i].data, VECS[i].logs, VECS[i].old, 2'd0);

    // R6 checkpoint when idle
    pulse_ckpt();
    check(epoch == 1, "R6 epoch step", 32'(epoch), 1);
    do_write(4'd3, 32'h6666_0003, 1'b1, 32'h5555_0003, 2'd1);

    // R5 back-pressure, R8 deferred checkpoint
    begin
      logic [DATA_W-1:0] held;
      int acc;
      @(negedge clk);
      log_ready = 1'b0; wr_valid = 1'b1; wr_line = 4'd5; wr_data = 32'h7777_0005;
      @(negedge clk); @(negedge clk); #1;
      check(log_valid, "R5 record up", 32'(log_valid), 1);
      held = log_data;
      check(held == 32'hC0DE_0005, "R2 old data stalled", held, 32'hC0DE_0005);
      ckpt_req = 1'b1;
      @(negedge clk); ckpt_req = 1'b0;
      for (int k = 0; k < 4; k++) begin
        #1;
        check(log_valid && log_data == held && log_line == 4'd5, "R5 record stable",
              log_data, held);
        check(!wr_ready, "R3 stall", 32'(wr_ready), 0);
        check(epoch == 1, "R8 epoch held", 32'(epoch), 1);
        @(negedge clk);
      end
      log_ready = 1'b1;
      @(negedge clk); #1;
      check(epoch == 1 && !wr_ready, "R8 apply cycle", 32'(epoch), 1);
      @(negedge clk); #1;
      check(epoch == 2, "R8 epoch after drain", 32'(epoch), 2);
      check(rd_en, "R8 flags cleared", 32'(rd_en), 1);
      acc = -1;
      for (int c = 0; c < 20 && acc < 0; c++) begin
        #1;
        if (log_valid) check(log_epoch == 2, "R2 relog epoch", 32'(log_epoch), 2);
        if (wr_ready) acc = c;
        @(negedge clk);
      end
      wr_valid = 1'b0;
      check(acc == 3, "R3 relog accept", 32'(acc), 3);
      check(mem[5] == 32'h7777_0005, "R9 memory written", mem[5], 32'h7777_0005);
    end

    // R7 wrap
    pulse_ckpt();
    check(epoch == 3, "R7 epoch 3", 32'(epoch), 3);
    pulse_ckpt();
    check(epoch == 0, "R7 wrap to 0", 32'(epoch), 0);

    // R6 pulse coinciding with a write to a touched line
    do_write(4'd9, 32'h8888_0009, 1'b1, 32'hC0DE_0009, 2'd0);
    @(negedge clk);
    wr_valid = 1'b1; wr_line = 4'd9; wr_data = 32'h9999_0009; ckpt_req = 1'b1; #1;
    check(!wr_ready && !mem_wr_en, "R6 write blocked", 32'(mem_wr_en), 0);
    @(negedge clk); ckpt_req = 1'b0; #1;
    check(epoch == 1, "R6 epoch step", 32'(epoch), 1);
    check(rd_en, "R6 flag cleared", 32'(rd_en), 1);
    for (int c = 0; c < 20 && !wr_ready; c++) begin @(negedge clk); #1; end
    @(negedge clk); wr_valid = 1'b0;
    check(mem[9] == 32'h9999_0009, "R9 memory written", mem[9], 32'h9999_0009);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule